// File: doc/BRIEF.md
# Burst-of-Two Dual-Port Static Memory

This block is a synthesizable, scaled-down model of a quad-data-rate static memory. It has a dedicated read port and a dedicated write port, and the two ports share one address bus. Each address stores a pair of words. Every access moves both words of the pair at once, on a first-word lane and a second-word lane. This stands in for the two data beats that a real part sends on both clock phases. A read and a write can be issued in the same clock cycle, and neither port ever waits on the other.

The shared address bus is split in time within each cycle. The rising clock edge captures the read address and the falling edge of the same cycle captures the write address. All inputs are registered before use. A write is held in a pending stage for one cycle and then committed to the array. A read that targets the pending address receives the new bytes, merged over the stored contents under the byte enables. Read data leaves through a pipeline register chain, and a valid flag, which stands in for the echo clock, marks the cycle in which the data appears.

Top module: `qdrBurstMem`

## Requirements
- R1: A read and a write issued in the same cycle are both carried out. Each uses its own data bus, with no added cycles.
- R2: In a cycle, the address bus value at the rising clock edge is the read address. The value at the following falling edge is the write address.
- R3: Each address holds two words. A read returns word 0 on `rdWord0` and word 1 on `rdWord1`. A write stores `wrWord0` as word 0 and `wrWord1` as word 1.
- R4: While `rdSelN` is high at a rising edge, no read is accepted, and `rdValid` stays low in the matching output cycle.
- R5: While `wrSelN` is high at a rising edge, the write data on the bus is ignored and the array keeps its contents.
- R6: A read accepted at a rising edge drives `rdValid` high with its data exactly `RD_LAT` rising edges later. Reads can be accepted on every cycle.
- R7: A read returns the state left by all writes issued in earlier cycles, including a write issued in the cycle just before. A write issued in the same cycle as the read does not affect it.
- R8: Byte enable bit i of `wrBe0`/`wrBe1` covers bits 8i+7..8i of the matching word. Bytes whose enable is low keep their stored value.
- R9: When a read hits a write that is still pending, it returns the enabled bytes of that write merged over the stored bytes.
- R10: While reset is held and right after it, `rdValid` is low and no write is pending. Writes presented during reset are not committed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; rising edge takes the read address and controls, falling edge the write address |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Shared address bus, time-split between read and write |
| rdSelN | input | 1 | Active-low read select |
| wrSelN | input | 1 | Active-low write select |
| wrWord0 | input | WORD_W | Write data, first burst word |
| wrWord1 | input | WORD_W | Write data, second burst word |
| wrBe0 | input | WORD_W/8 | Byte enables for the first word |
| wrBe1 | input | WORD_W/8 | Byte enables for the second word |
| rdWord0 | output | WORD_W | Read data, first burst word |
| rdWord1 | output | WORD_W | Read data, second burst word |
| rdValid | output | 1 | Marks the cycle in which read data is present |

## Verification
The hardest case to reach from the ports is a read that hits the write still held in the pending stage. It happens only when the read is issued exactly one cycle after a write to the same address. The bench builds this case on purpose, with full and with partial byte enables, so that the merge is exercised. Next to it, the bench issues a read and a write to the same address in one cycle, which must return the old data. It also repeats the read a few cycles later, to show that the committed path gives the same answer.

// File: rtl/qdrPkg.sv
package qdrPkg;
  // Strobes from control to datapath, one per pipeline action.
  typedef struct packed {
    logic rdLookup;  // a read accepted last edge is looked up now
    logic pendLoad;  // the write captured last edge moves into the pending stage
    logic commit;    // the pending stage holds a write to commit this edge
  } qdrStrobe_t;
endpackage

// File: rtl/qdrCtrl.sv
module qdrCtrl
  import qdrPkg::*;
#(
  parameter int RD_LAT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       rdSelN,
  input  logic       wrSelN,
  output qdrStrobe_t strb,
  output logic       rdValid
);
  logic              rdAcc;
  logic              wrAcc;
  logic              pendValid;
  logic [RD_LAT-1:0] validPipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdAcc     <= 1'b0;
      wrAcc     <= 1'b0;
      pendValid <= 1'b0;
      validPipe <= '0;
    end else begin
      rdAcc     <= ~rdSelN;
      wrAcc     <= ~wrSelN;
      pendValid <= wrAcc;
      validPipe <= {validPipe[RD_LAT-2:0], rdAcc};
    end
  end

  always_comb begin
    strb.rdLookup = rdAcc;
    strb.pendLoad = wrAcc;
    strb.commit   = pendValid;
  end

  assign rdValid = validPipe[RD_LAT-1];
endmodule

// File: rtl/qdrData.sv
module qdrData
  import qdrPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int RD_LAT = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  qdrStrobe_t            strb,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wrWord0,
  input  logic [WORD_W-1:0]     wrWord1,
  input  logic [WORD_W/8-1:0]   wrBe0,
  input  logic [WORD_W/8-1:0]   wrBe1,
  output logic [WORD_W-1:0]     rdWord0,
  output logic [WORD_W-1:0]     rdWord1
);
  localparam int BE_W   = WORD_W / 8;
  localparam int PAIR_W = 2 * WORD_W;
  localparam int PBE_W  = 2 * BE_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [ADDR_W-1:0] rdAddrQ, wrAddrQ, pendAddr;
  logic [PAIR_W-1:0] wrPairQ, pendPair, storedPair, mergedPair;
  logic [PBE_W-1:0]  wrBeQ, pendBe;
  logic [PAIR_W-1:0] mem [DEPTH];
  logic [PAIR_W-1:0] dataPipe [RD_LAT];
  logic              fwdHit;

  // Rising edge: read address and write data; falling edge: write address.
  always_ff @(posedge clk) begin
    rdAddrQ <= addr;
    wrPairQ <= {wrWord1, wrWord0};
    wrBeQ   <= {wrBe1, wrBe0};
  end

  always_ff @(negedge clk) wrAddrQ <= addr;

  always_ff @(posedge clk) begin
    if (strb.pendLoad) begin
      pendAddr <= wrAddrQ;
      pendPair <= wrPairQ;
      pendBe   <= wrBeQ;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commit) begin
      for (int b = 0; b < PBE_W; b++) begin
        if (pendBe[b]) mem[pendAddr][8*b +: 8] <= pendPair[8*b +: 8];
      end
    end
  end

  assign storedPair = mem[rdAddrQ];
  assign fwdHit     = strb.commit && (pendAddr == rdAddrQ);

  for (genvar b = 0; b < PBE_W; b++) begin : gMerge
    assign mergedPair[8*b +: 8] = (fwdHit && pendBe[b]) ? pendPair[8*b +: 8]
                                                        : storedPair[8*b +: 8];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              dataPipe[0] <= '0;
    else if (strb.rdLookup) dataPipe[0] <= mergedPair;
  end

  for (genvar s = 1; s < RD_LAT; s++) begin : gPipe
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dataPipe[s] <= '0;
      else       dataPipe[s] <= dataPipe[s-1];
    end
  end

  assign rdWord0 = dataPipe[RD_LAT-1][WORD_W-1:0];
  assign rdWord1 = dataPipe[RD_LAT-1][PAIR_W-1:WORD_W];
endmodule

// File: rtl/qdrBurstMem.sv
module qdrBurstMem
  import qdrPkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int WORD_W = 16,
  parameter int RD_LAT = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rdSelN,
  input  logic                wrSelN,
  input  logic [WORD_W-1:0]   wrWord0,
  input  logic [WORD_W-1:0]   wrWord1,
  input  logic [WORD_W/8-1:0] wrBe0,
  input  logic [WORD_W/8-1:0] wrBe1,
  output logic [WORD_W-1:0]   rdWord0,
  output logic [WORD_W-1:0]   rdWord1,
  output logic                rdValid
);
  qdrStrobe_t strb;

  qdrCtrl #(.RD_LAT(RD_LAT)) uCtrl (
    .clk(clk), .rstN(rstN), .rdSelN(rdSelN), .wrSelN(wrSelN),
    .strb(strb), .rdValid(rdValid)
  );

  qdrData #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RD_LAT(RD_LAT)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr),
    .wrWord0(wrWord0), .wrWord1(wrWord1), .wrBe0(wrBe0), .wrBe1(wrBe1),
    .rdWord0(rdWord0), .rdWord1(rdWord1)
  );
endmodule

// File: rtl/qdrBurstMemChk.sv
module qdrBurstMemChk #(
  parameter int RD_LAT = 2
) (
  input logic clk,
  input logic rstN,
  input logic rdSelN,
  input logic wrSelN,
  input logic rdValid,
  input logic pendActive
);
  logic [7:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 8'hFF) sinceRst <= sinceRst + 8'd1;
  end

  always @(posedge clk) begin
    if (!rstN) begin
      AST_IDLE_IN_RESET: assert (!rdValid && !pendActive); // R10
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 8'(RD_LAT + 1)) && $past(!rdSelN, RD_LAT + 1) |-> rdValid); // R6
  AST_READ_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 8'(RD_LAT + 1)) && $past(rdSelN, RD_LAT + 1) |-> !rdValid); // R4
  AST_WRITE_DESELECT: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 8'd2) && $past(wrSelN, 2) |-> !pendActive); // R5
  AST_WRITE_PENDING: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst >= 8'd2) && $past(!wrSelN, 2) |-> pendActive); // R1
endmodule

bind qdrBurstMem qdrBurstMemChk #(.RD_LAT(RD_LAT)) uChk (
  .clk(clk), .rstN(rstN), .rdSelN(rdSelN), .wrSelN(wrSelN),
  .rdValid(rdValid), .pendActive(strb.commit)
);

// File: tb/tb_qdrBurstMem.sv
module tb_qdrBurstMem;
  localparam int ADDR_W = 6;
  localparam int WORD_W = 16;
  localparam int RD_LAT = 2;
  localparam int BE_W   = WORD_W / 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              rdSelN = 1'b1, wrSelN = 1'b1;
  logic [WORD_W-1:0] wrWord0 = '0, wrWord1 = '0;
  logic [BE_W-1:0]   wrBe0 = '0, wrBe1 = '0;
  logic [WORD_W-1:0] rdWord0, rdWord1;
  logic              rdValid;

  qdrBurstMem #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .RD_LAT(RD_LAT)) dut (
    .clk(clk), .rstN(rstN), .addr(addr), .rdSelN(rdSelN), .wrSelN(wrSelN),
    .wrWord0(wrWord0), .wrWord1(wrWord1), .wrBe0(wrBe0), .wrBe1(wrBe1),
    .rdWord0(rdWord0), .rdWord1(rdWord1), .rdValid(rdValid)
  );

  always #4 clk = ~clk;  // 125 MHz

  int    nChecks = 0;
  int    nFails  = 0;
  bit    finished = 1'b0;
  int    cycN = 0;
  logic [WORD_W-1:0] refW0 [DEPTH];
  logic [WORD_W-1:0] refW1 [DEPTH];
  bit                exV  [64];
  logic [WORD_W-1:0] exD0 [64];
  logic [WORD_W-1:0] exD1 [64];
  string             exTag[64];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [WORD_W-1:0] act, input logic [WORD_W-1:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic clearRing();
    for (int i = 0; i < 64; i++) begin
      exV[i] = 1'b0; exTag[i] = "R10";
    end
    cycN = 0;
  endtask

  // One bus cycle: read address before the rising edge, write address before
  // the falling edge; outputs of the read RD_LAT cycles back are compared.
  task automatic cyc(input bit rdEn, input int rdA, input bit wrEn, input int wrA,
                     input logic [WORD_W-1:0] d0, input logic [WORD_W-1:0] d1,
                     input logic [BE_W-1:0] b0, input logic [BE_W-1:0] b1,
                     input string tag);
    int idx;
    @(negedge clk); #1;
    rdSelN = ~rdEn; wrSelN = ~wrEn; addr = ADDR_W'(rdA);
    wrWord0 = d0; wrWord1 = d1; wrBe0 = b0; wrBe1 = b1;
    idx = cycN % 64;
    exV[idx] = rdEn; exTag[idx] = tag;
    exD0[idx] = refW0[rdA]; exD1[idx] = refW1[rdA];
    if (wrEn) begin
      for (int b = 0; b < BE_W; b++) begin
        if (b0[b]) refW0[wrA][8*b +: 8] = d0[8*b +: 8];
        if (b1[b]) refW1[wrA][8*b +: 8] = d1[8*b +: 8];
      end
    end
    @(posedge clk); #1;
    addr = ADDR_W'(wrA);
    if (cycN >= RD_LAT) begin
      idx = (cycN - RD_LAT) % 64;
      check(rdValid == exV[idx], exTag[idx], "rdValid", WORD_W'(rdValid), WORD_W'(exV[idx]));
      if (exV[idx]) begin
        check(rdWord0 == exD0[idx], exTag[idx], "rdWord0", rdWord0, exD0[idx]);
        check(rdWord1 == exD1[idx], exTag[idx], "rdWord1", rdWord1, exD1[idx]);
      end
    end
    cycN++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 16'hFFFF, 16'hFFFF, '0, '0, "R6");
  endtask

  task automatic rd(input int a, input string tag);
    cyc(1, a, 0, 0, 16'hBAD0, 16'hBAD1, '1, '1, tag);
  endtask

  task automatic testReset();
    repeat (3) @(posedge clk);
    #1;
    check(rdValid == 1'b0, "R10", "rdValid in reset", WORD_W'(rdValid), '0);
    @(negedge clk); rstN = 1'b1;
    clearRing();
  endtask

  task automatic testFill();  // R3: distinct words per lane
    for (int a = 0; a < DEPTH; a++)
      cyc(0, 0, 1, a, WORD_W'(16'hA000 + a), WORD_W'(16'h5000 + 3*a), '1, '1, "R3");
    idle(RD_LAT + 1);
  endtask

  task automatic testStream();  // R6, R3: back-to-back reads
    for (int a = 0; a < DEPTH; a++) rd(a, "R6");
    idle(RD_LAT + 1);
  endtask

  task automatic testConcurrent();  // R1, R2
    cyc(1, 10, 1, 20, 16'h1111, 16'h2222, '1, '1, "R1");
    cyc(1, 20, 1, 11, 16'h3333, 16'h4444, '1, '1, "R2");
    idle(2);
    rd(10, "R2"); rd(11, "R2"); rd(20, "R1");
    idle(RD_LAT + 1);
  endtask

  task automatic testSameAddr();  // R7
    cyc(1, 30, 1, 30, 16'hC0DE, 16'hF00D, '1, '1, "R7");
    rd(30, "R7");
    idle(2);
    rd(30, "R7");
    cyc(1, 31, 1, 31, 16'h7777, 16'h8888, '1, '1, "R7");
    cyc(1, 31, 1, 31, 16'h9999, 16'hAAAA, '1, '1, "R7");
    rd(31, "R7");
    idle(RD_LAT + 1);
  endtask

  task automatic testBytes();  // R9 forwarded merge, R8 committed merge
    cyc(0, 0, 1, 40, 16'h1234, 16'h5678, 2'b01, 2'b10, "R9");
    rd(40, "R9");
    idle(2);
    rd(40, "R8");
    cyc(0, 0, 1, 41, 16'hEEEE, 16'hDDDD, 2'b00, 2'b00, "R8");
    idle(2);
    rd(41, "R8");
    idle(RD_LAT + 1);
  endtask

  task automatic testRdDeselect();  // R4
    cyc(0, 50, 1, 50, 16'h4242, 16'h2424, '1, '1, "R4");
    cyc(0, 51, 0, 0, 16'h0, 16'h0, '0, '0, "R4");
    idle(RD_LAT);
    rd(50, "R4");
    idle(RD_LAT + 1);
  endtask

  task automatic testWrDeselect();  // R5
    cyc(1, 60, 0, 60, 16'hDEAD, 16'hBEEF, '1, '1, "R5");
    rd(60, "R5");
    idle(2);
    rd(60, "R5");
    idle(RD_LAT + 1);
  endtask

  task automatic testWriteInReset();  // R10
    @(negedge clk);
    rstN = 1'b0; rdSelN = 1'b1; wrSelN = 1'b0; addr = ADDR_W'(3);
    wrWord0 = 16'hDEAD; wrWord1 = 16'hDEAD; wrBe0 = '1; wrBe1 = '1;
    repeat (3) @(posedge clk);
    #1;
    check(rdValid == 1'b0, "R10", "rdValid in reset", WORD_W'(rdValid), '0);
    @(negedge clk);
    wrSelN = 1'b1; rstN = 1'b1;
    clearRing();
    #1;
    check(rdValid == 1'b0, "R10", "rdValid after reset", WORD_W'(rdValid), '0);
    idle(2);
    rd(3, "R10");
    idle(RD_LAT + 1);
  endtask

  initial begin
    testReset();
    testFill();
    testStream();
    testConcurrent();
    testSameAddr();
    testBytes();
    testRdDeselect();
    testWrDeselect();
    testWriteInReset();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule